// File: doc/BRIEF.md
# Grouped interrupt status controller

This block is the interrupt unit of a network controller. It keeps a 32-bit status register of event flags and a 32-bit enable register. Single-cycle pulses from the controller's event sources set flags in the status register; a CPU register port replaces the enable register and clears status flags by writing ones to them. Bits that a write cannot clear, such as the process-state field in the top nibble, keep whatever value they hold.

From the flags and their enables the block rebuilds two summary bits, normal and abnormal, after every update. Each summary bit stands for a fixed group of causes and is never sticky: it is recomputed from the current flags and enables, so it drops as soon as its last enabled cause is cleared or masked. The single level interrupt line is raised when a summary bit is set and that summary bit is itself enabled. The line is registered and follows the status register by one clock.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Synchronous active-low reset loads status with 0xF0000000, enable with 0xF3FE0000 and drives `irq_o` low.
- R2: An `evt_pulse` bit at an event position (0 to 14, 26, 27) sets the same status bit on the next clock; pulses at any other position change nothing.
- R3: A write with `reg_sel`=0 clears exactly the status bits at event positions and summary positions (15, 16) that are 1 in `reg_wdata`; bits 17 to 25 and 28 to 31 are never changed by a write.
- R4: When an event pulse and a clearing write hit the same bit in one cycle, the bit ends up set.
- R5: A write with `reg_sel`=1 replaces the whole enable register with `reg_wdata` on the next clock.
- R6: Status bit 16 (normal) is 1 exactly when some flag among bits 0, 2, 6, 11, 14 is set with its enable bit set.
- R7: Status bit 15 (abnormal) is 1 exactly when some flag among bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26, 27 is set with its enable bit set.
- R8: The summary bits are rebuilt on every update with the new flags and the new enable value, so writing 1 to a summary bit while its cause stays enabled leaves it set, and masking or clearing the last cause drops it in the same clock.
- R9: `irq_o` equals, one clock later, the OR of (status bit 15 AND enable bit 15) and (status bit 16 AND enable bit 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Write target: 0 status (clear-by-one), 1 enable (replace) |
| reg_wdata | input | 32 | Write data |
| evt_pulse | input | 32 | Event set pulses, one bit per status position |
| status_o | output | 32 | Current status register |
| enable_o | output | 32 | Current enable register |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions assume that reset is held low with quiet write and event inputs until the first clock edge, and that writes and pulses are sampled only on rising edges; the stimulus drives every input on the falling edge and keeps them at zero while reset is low. The vector walk crosses both summary groups, toggles the enable of a cause and of a summary bit separately, and combines a pulse with a clearing write on the same bit, so each grouping and precedence rule is visible at the ports. Pulses and writes at positions outside the event set are mixed in to show they leave the register untouched.

// File: rtl/grp_irq_pkg.sv
// Package: bit positions, group masks and reset values shared by the
// grouped interrupt status controller. Assumes a 32-bit register width.
package grp_irq_pkg;

    localparam int REG_W = 32;

    // Event and summary bit positions
    localparam int B_TX_DONE   = 0;
    localparam int B_TX_STOP   = 1;
    localparam int B_TX_UNAV   = 2;
    localparam int B_JABBER    = 3;
    localparam int B_LINK_PASS = 4;
    localparam int B_UNDERFLOW = 5;
    localparam int B_RX_DONE   = 6;
    localparam int B_RX_UNAV   = 7;
    localparam int B_RX_STOP   = 8;
    localparam int B_RX_WDOG   = 9;
    localparam int B_EARLY_TX  = 10;
    localparam int B_TIMER     = 11;
    localparam int B_LINK_FAIL = 12;
    localparam int B_BUS_ERR   = 13;
    localparam int B_EARLY_RX  = 14;
    localparam int B_SUM_ABN   = 15;
    localparam int B_SUM_NORM  = 16;
    localparam int B_GP        = 26;
    localparam int B_LINK_CHG  = 27;

    localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

    localparam logic [REG_W-1:0] NORM_GRP =
        (ONE << B_TX_DONE) | (ONE << B_TX_UNAV) | (ONE << B_RX_DONE) |
        (ONE << B_TIMER)   | (ONE << B_EARLY_RX);

    localparam logic [REG_W-1:0] ABN_GRP =
        (ONE << B_TX_STOP)   | (ONE << B_JABBER)   | (ONE << B_LINK_PASS) |
        (ONE << B_UNDERFLOW) | (ONE << B_RX_UNAV)  | (ONE << B_RX_STOP)   |
        (ONE << B_RX_WDOG)   | (ONE << B_EARLY_TX) | (ONE << B_LINK_FAIL) |
        (ONE << B_BUS_ERR)   | (ONE << B_GP)       | (ONE << B_LINK_CHG);

    localparam logic [REG_W-1:0] EVT_MASK = NORM_GRP | ABN_GRP;
    localparam logic [REG_W-1:0] SUM_MASK = (ONE << B_SUM_ABN) | (ONE << B_SUM_NORM);
    localparam logic [REG_W-1:0] CLR_MASK = EVT_MASK | SUM_MASK;
    localparam logic [REG_W-1:0] KEEP_MASK = ~CLR_MASK;

    localparam logic [REG_W-1:0] RST_STATUS = 32'hF000_0000;
    localparam logic [REG_W-1:0] RST_ENABLE = 32'hF3FE_0000;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/grp_irq_enable_reg.sv
// Enable register: replaced whole by a CPU write. Also exposes the value
// it will hold after this clock so the summary logic sees the new mask
// in the same update. Assumes one write strobe per cycle at most.
module grp_irq_enable_reg
    import grp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_next,
    output logic [REG_W-1:0] en_q
);

    // Next value: new data on a write, otherwise hold
    always_comb begin
        en_next = wr_en ? wdata : en_q;
    end

    // Register with reset value
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= RST_ENABLE;
        else        en_q <= en_next;
    end

    // R5: a write replaces the enable register
    assert_enable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == $past(wdata));

endmodule

// File: rtl/grp_irq_summary.sv
// Summary builder: purely combinational, rebuilds the normal and abnormal
// bits from the flags and enables of the coming update. Assumes the group
// masks in the package never overlap.
module grp_irq_summary
    import grp_irq_pkg::*;
(
    input  logic [REG_W-1:0] events,
    input  logic [REG_W-1:0] enables,
    output logic             sum_norm,
    output logic             sum_abn
);

    logic [REG_W-1:0] live;

    // Enabled causes, then OR-reduction per fixed group
    always_comb begin
        live     = events & enables;
        sum_norm = |(live & NORM_GRP);
        sum_abn  = |(live & ABN_GRP);
    end

endmodule

// File: rtl/grp_irq_status_reg.sv
// Status register: event pulses set flags, a status write clears the
// flags written as one, set beats clear on the same bit, and the summary
// bits are stored from the summary builder every clock. Bits outside the
// event and summary positions are held. Assumes pulses last one cycle.
module grp_irq_status_reg
    import grp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_data,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic             sum_norm,
    input  logic             sum_abn,
    output logic [REG_W-1:0] evt_next,
    output logic [REG_W-1:0] st_q
);

    logic [REG_W-1:0] clr_bits;
    logic [REG_W-1:0] set_bits;
    logic [REG_W-1:0] st_next;

    // Event flags of the coming update: clear first, set wins
    always_comb begin
        clr_bits = clr_en ? (clr_data & EVT_MASK) : '0;
        set_bits = evt_pulse & EVT_MASK;
        evt_next = ((st_q & EVT_MASK) & ~clr_bits) | set_bits;
    end

    // Full next value: held bits, new flags, freshly built summaries
    always_comb begin
        st_next = (st_q & KEEP_MASK) | evt_next;
        st_next[B_SUM_NORM] = sum_norm;
        st_next[B_SUM_ABN]  = sum_abn;
    end

    // Register with reset value
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATUS;
        else        st_q <= st_next;
    end

    // R2/R4: a pulsed event bit is set after the clock, even when cleared
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & EVT_MASK)) |=>
            ((st_q & $past(evt_pulse & EVT_MASK)) == $past(evt_pulse & EVT_MASK)));

    // R3: bits outside event and summary positions never change
    assert_keep_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q & KEEP_MASK) == $past(st_q & KEEP_MASK));

    // R2: with no pulse and no write, event flags hold
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && evt_pulse == '0) |=> (st_q & EVT_MASK) == $past(st_q & EVT_MASK));

endmodule

// File: rtl/grp_irq_line.sv
// Interrupt line: registers the OR of each summary bit gated by its own
// enable bit, so the output trails the status register by one clock.
module grp_irq_line
    import grp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] st_q,
    input  logic [REG_W-1:0] en_q,
    output logic             irq_q
);

    logic raise;

    // Gate summaries by their enables
    always_comb begin
        raise = |(st_q & en_q & SUM_MASK);
    end

    // Registered level output
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= raise;
    end

    // R9: output follows gated summaries of the previous clock
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_q == $past((st_q[B_SUM_NORM] & en_q[B_SUM_NORM]) |
                                (st_q[B_SUM_ABN]  & en_q[B_SUM_ABN])));

endmodule

// File: rtl/grp_irq_ctrl.sv
// Top of the grouped interrupt status controller: wires the enable
// register, status register, summary builder and interrupt line. Assumes
// a single-cycle write strobe and single-cycle event pulses on clk.
module grp_irq_ctrl
    import grp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [REG_W-1:0] evt_pulse,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             irq_o
);

    logic             wr_status;
    logic             wr_enable;
    logic [REG_W-1:0] en_next;
    logic [REG_W-1:0] evt_next;
    logic             sum_norm;
    logic             sum_abn;

    // Decode the write target
    always_comb begin
        wr_status = reg_wr && (reg_sel == SEL_STATUS);
        wr_enable = reg_wr && (reg_sel == SEL_ENABLE);
    end

    grp_irq_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_enable),
        .wdata   (reg_wdata),
        .en_next (en_next),
        .en_q    (enable_o)
    );

    grp_irq_summary u_sum (
        .events   (evt_next),
        .enables  (en_next),
        .sum_norm (sum_norm),
        .sum_abn  (sum_abn)
    );

    grp_irq_status_reg u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (wr_status),
        .clr_data  (reg_wdata),
        .evt_pulse (evt_pulse),
        .sum_norm  (sum_norm),
        .sum_abn   (sum_abn),
        .evt_next  (evt_next),
        .st_q      (status_o)
    );

    grp_irq_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .st_q  (status_o),
        .en_q  (enable_o),
        .irq_q (irq_o)
    );

    // R6: stored normal bit matches the enabled normal group
    assert_norm_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_SUM_NORM] == |(status_o & enable_o & NORM_GRP));

    // R7: stored abnormal bit matches the enabled abnormal group
    assert_abn_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_SUM_ABN] == |(status_o & enable_o & ABN_GRP));

endmodule

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] evt_pulse = '0;
    logic [31:0] status_o;
    logic [31:0] enable_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    grp_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .evt_pulse (evt_pulse),
        .status_o  (status_o),
        .enable_o  (enable_o),
        .irq_o     (irq_o)
    );

    // op: 0 idle, 1 status write (clear), 2 enable write
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] data;
        logic [31:0] evt;
        logic [31:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd2, 32'h0001_8041, 32'h0000_0000, 32'hF000_0000, 1'b0}, // R5 enable 16,15,6,0
        '{2'd0, 32'h0000_0000, 32'h0000_0001, 32'hF001_0001, 1'b1}, // R2 R6 tx-done
        '{2'd0, 32'h0000_0000, 32'h0010_0004, 32'hF001_0005, 1'b1}, // R2 masked cause, bit20 ignored
        '{2'd1, 32'h0000_0001, 32'h0000_0000, 32'hF000_0004, 1'b0}, // R3 R8 clear tx-done
        '{2'd0, 32'h0000_0000, 32'h0000_2000, 32'hF000_2004, 1'b0}, // R7 bus-error not enabled
        '{2'd2, 32'h0000_A000, 32'h0000_0000, 32'hF000_A004, 1'b1}, // R7 R8 enable 15,13
        '{2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'hF000_0000, 1'b0}, // R3 clear all
        '{2'd1, 32'h0000_2000, 32'h0000_2000, 32'hF000_A000, 1'b1}, // R4 set beats clear
        '{2'd1, 32'h0000_8000, 32'h0000_0000, 32'hF000_A000, 1'b1}, // R8 summary not clearable
        '{2'd2, 32'h0000_8000, 32'h0000_0000, 32'hF000_2000, 1'b0}, // R8 mask cause
        '{2'd0, 32'h0000_0000, 32'h0800_0000, 32'hF800_2000, 1'b0}, // R2 link-changed
        '{2'd2, 32'h0800_8000, 32'h0000_0000, 32'hF800_A000, 1'b1}, // R7 enable link-changed
        '{2'd2, 32'h0800_0000, 32'h0000_0000, 32'hF800_A000, 1'b0}  // R9 summary enable off
    };

    function automatic string req_of(int i);
        case (i)
            0:  return "R5";
            1:  return "R6";
            2:  return "R2";
            3:  return "R3";
            4:  return "R7";
            5:  return "R8";
            6:  return "R3";
            7:  return "R4";
            8:  return "R8";
            9:  return "R8";
            10: return "R2";
            11: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] data,
                         input logic [31:0] evt);
        @(negedge clk);
        reg_wr    = (op != 2'd0);
        reg_sel   = (op == 2'd2);
        reg_wdata = data;
        evt_pulse = evt;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_sel   = 1'b0;
        reg_wdata = '0;
        evt_pulse = '0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Reset state, checked while reset is held (R1)
        repeat (3) @(negedge clk);
        chk("R1", "status", status_o, 32'hF000_0000);
        chk("R1", "enable", enable_o, 32'hF3FE_0000);
        chk("R1", "irq", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;

        // Vector walk: status/enable after one edge, irq after the next
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].data, VECS[i].evt);
            chk(req_of(i), $sformatf("vec%0d status", i), status_o, VECS[i].st);
            if (VECS[i].op == 2'd2)
                chk("R5", $sformatf("vec%0d enable", i), enable_o, VECS[i].data);
            @(negedge clk);
            chk("R9", $sformatf("vec%0d irq", i), {31'd0, irq_o}, {31'd0, VECS[i].irq});
        end

        // Reset in mid-run restores reset values (R1)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "re-reset status", status_o, 32'hF000_0000);
        chk("R1", "re-reset enable", enable_o, 32'hF3FE_0000);
        chk("R1", "re-reset irq", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;

        // All pulse lines at once: only event positions set, none enabled (R2 R6 R7)
        drive(2'd0, 32'h0, 32'hFFFF_FFFF);
        chk("R2", "all pulses", status_o, 32'hFC00_7FFF);
        @(negedge clk);
        chk("R9", "all pulses irq", {31'd0, irq_o}, 32'd0);

        // Clear everything by write; state nibble stays (R3)
        drive(2'd1, 32'hFFFF_FFFF, 32'h0);
        chk("R3", "clear all", status_o, 32'hF000_0000);

        // Normal summary via early-receive with summary enable (R6 R9)
        drive(2'd2, 32'h0001_4000, 32'h0);
        drive(2'd0, 32'h0, 32'h0000_4000);
        chk("R6", "early-rx normal", status_o, 32'hF001_4000);
        @(negedge clk);
        chk("R9", "early-rx irq", {31'd0, irq_o}, 32'd1);

        // Clear early-receive: normal drops same clock, irq one later (R8 R9)
        drive(2'd1, 32'h0000_4000, 32'h0);
        chk("R8", "normal drops", status_o, 32'hF000_0000);
        chk("R9", "irq still high one clock", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        chk("R9", "irq low", {31'd0, irq_o}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule